// File: doc/BRIEF.md
# Dual-Channel Serial Register Front End

This block sits between a small byte-wide host bus and the two channel datapaths of a serial communications controller. Each channel has sixteen write registers and sixteen read registers. The host does not address them directly. It first writes a pointer through the channel's control port. The next control access then reaches the register that the pointer selects, and the pointer drops back to zero. A control write made while the pointer is zero can also carry a command.

The block keeps the receive and transmit status bits of each channel. It offers a byte-wide receive handshake (valid in, ready out) and a transmit pulse to each datapath. It raises per-channel pending flags for transmit and receive interrupt requests, which the interrupt vector logic downstream consumes. One write register is decoded across both channels: depending on its top bits, it returns channel A, channel B or both channels to their reset state.

The bus is synchronous. Writes are single-cycle strobes. Read data is registered and appears one cycle after the read strobe.

Top module: `duo_serial_regs`

## Requirements
- R1: Address bit 2 selects the channel (1 = channel A, index 1 of every per-channel port; 0 = channel B, index 0) and address bit 0 selects the port (0 = control, 1 = data). An access to one channel leaves the other channel's state unchanged.
- R2: A control write while the pointer is 0 loads the pointer with data bits 2:0. If data bits 5:3 equal 001, it also adds 8 to the pointer.
- R3: After any control write or read made while the pointer is nonzero, the pointer is 0. A control read returns read register [pointer]. Read registers other than 0 and 1 read 0x00.
- R4: A write to write register 9 whose bits 7:6 are 01 resets channel B, 10 resets channel A and 11 resets both, and that value is not stored. When bits 7:6 are 00 the value is stored and nothing is reset.
- R5: After reset, read register 0 is 0x44 and read register 1 is 0x06. Write registers 4, 9, 11, 14 and 15 hold 0x04, 0xC0, 0x08, 0x30 and 0xF8. Every other register, the pointer and all pending flags are 0, so receive and transmit are disabled.
- R6: A data-port write latches the byte. It pulses tx_valid for one cycle, the cycle after the write, with that byte on tx_data, but only if write register 5 bit 3 is set. It also sets read register 0 bit 2 and read register 1 bit 0, and sets tx_irq.
- R7: rx_ready is high only while write register 3 bit 0 is 1 and read register 0 bit 0 is 0. A byte offered while rx_ready is high is latched, sets read register 0 bit 0 and sets rx_irq. A byte offered while rx_ready is low is dropped.
- R8: A data-port read returns the latched receive byte, clears read register 0 bit 0 and clears rx_irq.
- R9: A pulse on rx_break sets read register 0 bit 7 of that channel. The bit stays set until that channel is reset.
- R10: A control write with data bits 5:3 = 101, made while the pointer is 0, clears that channel's tx_irq.
- R11: A control write with data bits 5:3 = 111, made while the pointer is 0, pulses that channel's ius_done for exactly one cycle, the cycle after the write.
- R12: bus_rdata changes only in the cycle after a read strobe and holds its value while no read is made.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_addr | input | 3 | Byte address within the 8-byte window |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| tx_valid | output | 2 | Per-channel transmit byte pulse |
| tx_data | output | 2*DATA_W | Per-channel transmit byte |
| rx_valid | input | 2 | Per-channel receive byte offer |
| rx_data | input | 2*DATA_W | Per-channel receive byte |
| rx_ready | output | 2 | Per-channel receiver can take a byte |
| rx_break | input | 2 | Per-channel break detected pulse |
| tx_irq | output | 2 | Transmit interrupt pending |
| rx_irq | output | 2 | Receive interrupt pending |
| ius_done | output | 2 | Pulse asking for the highest in-service interrupt to be reset |

## Verification
The pointer is driven with three kinds of pointer write: a plain load, a load with the add-8 command, and a load that carries another command. Reading register 9 as 0x00 rather than register 1's 0x06 shows that the add was applied. Bytes are offered to the receiver both while it is ready and while it holds an unread character, so a dropped byte shows up as the wrong value on the following data read. The cross-channel reset register is written with each of its reset codes and with code 00, from both channels. Afterwards the bench checks which channel's status, receive enable and transmit enable returned to reset, and that the other channel kept its state.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
   localparam int NCH        = 2;
   localparam int REG_RXCFG  = 3;
   localparam int REG_TXCFG  = 5;
   localparam int REG_RSTSEL = 9;
   localparam int RXEN_BIT   = 0;
   localparam int TXEN_BIT   = 3;
   localparam logic [2:0] CMD_HIGH   = 3'b001;
   localparam logic [2:0] CMD_TXACK  = 3'b101;
   localparam logic [2:0] CMD_IUSCLR = 3'b111;
   localparam logic [7:0] ST0_INIT   = 8'h44;
   localparam logic [7:0] ST1_INIT   = 8'h06;

   function automatic logic [7:0] wr_init(input int idx);
      case (idx)
         4:       return 8'h04;
         9:       return 8'hC0;
         11:      return 8'h08;
         14:      return 8'h30;
         15:      return 8'hF8;
         default: return 8'h00;
      endcase
   endfunction
endpackage

// File: rtl/dsr_decode.sv
module dsr_decode #(
   parameter int NCH = 2
) (
   input  logic           bus_wr,
   input  logic           bus_rd,
   input  logic [2:0]     bus_addr,
   output logic [NCH-1:0] ctl_wr,
   output logic [NCH-1:0] ctl_rd,
   output logic [NCH-1:0] dat_wr,
   output logic [NCH-1:0] dat_rd
);
   logic rd_ok;
   assign rd_ok = bus_rd & ~bus_wr;

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      logic hit;
      assign hit       = (bus_addr[2] == 1'(c));
      assign ctl_wr[c] = bus_wr & hit & ~bus_addr[0];
      assign dat_wr[c] = bus_wr & hit &  bus_addr[0];
      assign ctl_rd[c] = rd_ok  & hit & ~bus_addr[0];
      assign dat_rd[c] = rd_ok  & hit &  bus_addr[0];
   end
endmodule

// File: rtl/dsr_chan.sv
module dsr_chan #(
   parameter int DATA_W  = 8,
   parameter int REG_CNT = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              ctl_wr,
   input  logic              ctl_rd,
   input  logic              dat_wr,
   input  logic              dat_rd,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] ctl_rval,
   output logic [DATA_W-1:0] dat_rval,
   output logic [1:0]        rst_req,
   output logic              tx_valid,
   output logic [DATA_W-1:0] tx_data,
   input  logic              rx_valid,
   input  logic [DATA_W-1:0] rx_data,
   output logic              rx_ready,
   input  logic              rx_break,
   output logic              tx_irq,
   output logic              rx_irq,
   output logic              ius_done
);
   import dsr_pkg::*;
   localparam int PTR_W = $clog2(REG_CNT);

   if (DATA_W < 8) begin : g_bad_width
      $error("dsr_chan: DATA_W must be at least 8");
   end
   if (REG_CNT != 16) begin : g_bad_depth
      $error("dsr_chan: REG_CNT must be 16");
   end

   logic [DATA_W-1:0] wreg [REG_CNT];
   logic [PTR_W-1:0]  ptr;
   logic [DATA_W-1:0] st0, st1, rx_byte;
   logic              tx_pend, rx_pend, ius_q;
   logic [2:0]        cmd;
   logic              ptr_idle, sel_rst, store, accept;

   assign cmd      = wdata[5:3];
   assign ptr_idle = (ptr == '0);
   assign sel_rst  = ctl_wr & ~ptr_idle & (ptr == PTR_W'(REG_RSTSEL));
   assign rst_req  = sel_rst ? wdata[7:6] : 2'b00;
   assign store    = ctl_wr & ~ptr_idle & ~(sel_rst & (wdata[7:6] != 2'b00));
   assign rx_ready = wreg[REG_RXCFG][RXEN_BIT] & ~st0[0];
   assign accept   = rx_valid & rx_ready;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < REG_CNT; i++) wreg[i] <= DATA_W'(wr_init(i));
      end else if (soft_rst) begin
         for (int i = 0; i < REG_CNT; i++) wreg[i] <= DATA_W'(wr_init(i));
      end else if (store) begin
         wreg[ptr] <= wdata;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ptr <= '0; st0 <= DATA_W'(ST0_INIT); st1 <= DATA_W'(ST1_INIT);
         rx_byte <= '0; tx_pend <= 1'b0; rx_pend <= 1'b0; ius_q <= 1'b0;
         tx_valid <= 1'b0; tx_data <= '0;
      end else if (soft_rst) begin
         ptr <= '0; st0 <= DATA_W'(ST0_INIT); st1 <= DATA_W'(ST1_INIT);
         rx_byte <= '0; tx_pend <= 1'b0; rx_pend <= 1'b0; ius_q <= 1'b0;
         tx_valid <= 1'b0; tx_data <= '0;
      end else begin
         tx_valid <= 1'b0;
         ius_q    <= 1'b0;
         if (ctl_wr) begin
            if (ptr_idle) begin
               ptr <= PTR_W'(wdata[2:0]) | ((cmd == CMD_HIGH) ? PTR_W'(8) : '0);
               if (cmd == CMD_TXACK)  tx_pend <= 1'b0;
               if (cmd == CMD_IUSCLR) ius_q   <= 1'b1;
            end else begin
               ptr <= '0;
            end
         end
         if (ctl_rd) ptr <= '0;
         if (dat_wr) begin
            tx_data  <= wdata;
            tx_valid <= wreg[REG_TXCFG][TXEN_BIT];
            st0[2]   <= 1'b1;
            st1[0]   <= 1'b1;
            tx_pend  <= 1'b1;
         end
         if (dat_rd) begin
            st0[0]  <= 1'b0;
            rx_pend <= 1'b0;
         end
         if (accept) begin
            rx_byte <= rx_data;
            st0[0]  <= 1'b1;
            rx_pend <= 1'b1;
         end
         if (rx_break) st0[7] <= 1'b1;
      end
   end

   always_comb begin
      if (ptr == PTR_W'(0))      ctl_rval = st0;
      else if (ptr == PTR_W'(1)) ctl_rval = st1;
      else                       ctl_rval = '0;
   end
   assign dat_rval = rx_byte;
   assign tx_irq   = tx_pend;
   assign rx_irq   = rx_pend;
   assign ius_done = ius_q;

   AST_PTR_RETURN: assert property (@(posedge clk) disable iff (!rst_n)
      ((ctl_wr || ctl_rd) && !ptr_idle) |=> (ptr == '0)); // R3
   AST_TX_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_wr && !soft_rst) |=> (st0[2] && st1[0] && tx_irq)); // R6
   AST_RX_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_ready && !soft_rst) |=> (st0[0] && rx_irq && !rx_ready)); // R7
   AST_RX_READ_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (dat_rd && !accept && !soft_rst) |=> (!st0[0] && !rx_irq)); // R8
   AST_BREAK_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_break && !soft_rst) |=> st0[7]); // R9
   AST_SOFT_INIT: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (ptr == '0 && st0 == DATA_W'(ST0_INIT) && !tx_irq && !rx_irq)); // R4
endmodule

// File: rtl/duo_serial_regs.sv
module duo_serial_regs #(
   parameter int DATA_W  = 8,
   parameter int REG_CNT = 16
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            bus_wr,
   input  logic                            bus_rd,
   input  logic [2:0]                      bus_addr,
   input  logic [DATA_W-1:0]               bus_wdata,
   output logic [DATA_W-1:0]               bus_rdata,
   output logic [dsr_pkg::NCH-1:0]         tx_valid,
   output logic [dsr_pkg::NCH*DATA_W-1:0]  tx_data,
   input  logic [dsr_pkg::NCH-1:0]         rx_valid,
   input  logic [dsr_pkg::NCH*DATA_W-1:0]  rx_data,
   output logic [dsr_pkg::NCH-1:0]         rx_ready,
   input  logic [dsr_pkg::NCH-1:0]         rx_break,
   output logic [dsr_pkg::NCH-1:0]         tx_irq,
   output logic [dsr_pkg::NCH-1:0]         rx_irq,
   output logic [dsr_pkg::NCH-1:0]         ius_done
);
   localparam int NCH = dsr_pkg::NCH;

   logic [NCH-1:0]    ctl_wr, ctl_rd, dat_wr, dat_rd, soft_rst;
   logic [DATA_W-1:0] ctl_rv [NCH];
   logic [DATA_W-1:0] dat_rv [NCH];
   logic [1:0]        req    [NCH];

   dsr_decode #(.NCH(NCH)) u_dec (
      .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .dat_wr(dat_wr), .dat_rd(dat_rd)
   );

   always_comb begin
      soft_rst = '0;
      for (int s = 0; s < NCH; s++) soft_rst = soft_rst | req[s];
   end

   for (genvar c = 0; c < NCH; c++) begin : g_chan
      dsr_chan #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_chan (
         .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst[c]),
         .ctl_wr(ctl_wr[c]), .ctl_rd(ctl_rd[c]),
         .dat_wr(dat_wr[c]), .dat_rd(dat_rd[c]),
         .wdata(bus_wdata), .ctl_rval(ctl_rv[c]), .dat_rval(dat_rv[c]),
         .rst_req(req[c]),
         .tx_valid(tx_valid[c]), .tx_data(tx_data[c*DATA_W +: DATA_W]),
         .rx_valid(rx_valid[c]), .rx_data(rx_data[c*DATA_W +: DATA_W]),
         .rx_ready(rx_ready[c]), .rx_break(rx_break[c]),
         .tx_irq(tx_irq[c]), .rx_irq(rx_irq[c]), .ius_done(ius_done[c])
      );
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata <= '0;
      end else if (bus_rd && !bus_wr) begin
         bus_rdata <= bus_addr[0] ? dat_rv[bus_addr[2]] : ctl_rv[bus_addr[2]];
      end
   end

   AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_rd || bus_wr) |=> $stable(bus_rdata)); // R12
   AST_IUS_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (ius_done != '0) |=> (ius_done == '0 || $past(ctl_wr) != '0)); // R11
endmodule

// File: tb/duo_serial_regs_tb.sv
module duo_serial_regs_tb;
   localparam int DW = 8;
   localparam logic [2:0] A_CTL = 3'b100, A_DAT = 3'b101, B_CTL = 3'b000, B_DAT = 3'b001;

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_wr = 0, bus_rd = 0;
   logic [2:0] bus_addr = '0;
   logic [DW-1:0] bus_wdata = '0, bus_rdata;
   logic [1:0] tx_valid, rx_valid = '0, rx_ready, rx_break = '0, tx_irq, rx_irq, ius_done;
   logic [2*DW-1:0] tx_data, rx_data = '0;

   int tests = 0, fails = 0;
   logic [7:0] rd_exp_q[$];
   string      rd_tag_q[$];
   logic [7:0] tx_exp_q0[$];
   logic [7:0] tx_exp_q1[$];
   logic rd_seen = 1'b0;

   always #5 clk = ~clk;

   duo_serial_regs u_dut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .tx_valid(tx_valid), .tx_data(tx_data), .rx_valid(rx_valid),
      .rx_data(rx_data), .rx_ready(rx_ready), .rx_break(rx_break),
      .tx_irq(tx_irq), .rx_irq(rx_irq), .ius_done(ius_done)
   );

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   // Read monitor: pops the scoreboard one cycle after each read strobe
   always @(posedge clk) rd_seen <= bus_rd && !bus_wr;
   always @(negedge clk) begin
      if (rd_seen) begin
         if (rd_exp_q.size() == 0) chk(bus_rdata, 8'hxx, "R12 unexpected read");
         else chk(bus_rdata, rd_exp_q.pop_front(), rd_tag_q.pop_front());
      end
   end

   // Transmit monitor
   always @(negedge clk) begin
      if (tx_valid[0]) begin
         if (tx_exp_q0.size() == 0) chk(8'h01, 8'h00, "R6 unexpected tx on B");
         else chk(tx_data[7:0], tx_exp_q0.pop_front(), "R6 tx byte B");
      end
      if (tx_valid[1]) begin
         if (tx_exp_q1.size() == 0) chk(8'h01, 8'h00, "R6 unexpected tx on A");
         else chk(tx_data[15:8], tx_exp_q1.pop_front(), "R6 tx byte A");
      end
   end

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic wr_dat(input int ch, input logic [7:0] d, input bit exp_tx);
      if (exp_tx) begin
         if (ch == 1) tx_exp_q1.push_back(d); else tx_exp_q0.push_back(d);
      end
      wr(ch == 1 ? A_DAT : B_DAT, d);
   endtask

   task automatic rd(input logic [2:0] a, input logic [7:0] exp, input string tag);
      rd_exp_q.push_back(exp); rd_tag_q.push_back(tag);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
   endtask

   task automatic rx_offer(input int ch, input logic [7:0] d);
      rx_valid[ch] = 1'b1; rx_data[ch*DW +: DW] = d;
      @(negedge clk);
      rx_valid[ch] = 1'b0;
   endtask

   initial begin : watchdog
      #2_000_000;
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R5 reset state at the ports
      chk({6'b0, tx_irq}, 8'h00, "R5 tx_irq after reset");
      chk({6'b0, rx_irq}, 8'h00, "R5 rx_irq after reset");
      chk({6'b0, rx_ready}, 8'h00, "R5 rx disabled after reset");
      rd(A_CTL, 8'h44, "R5 R1 A status 0");
      rd(B_CTL, 8'h44, "R5 B status 0");
      // R2 pointer load, R3 return
      wr(A_CTL, 8'h01);
      rd(A_CTL, 8'h06, "R2 R5 A reg 1");
      rd(A_CTL, 8'h44, "R3 pointer back to 0");
      @(negedge clk);
      chk(bus_rdata, 8'h44, "R12 rdata held without read");
      wr(A_CTL, 8'h09);
      rd(A_CTL, 8'h00, "R2 add-8 reaches reg 9, R3 reads 0");
      // R7 receive enable on A only
      wr(A_CTL, 8'h03); wr(A_CTL, 8'h01);
      chk({6'b0, rx_ready}, 8'h02, "R1 R7 rx_ready A only");
      rx_offer(1, 8'hA5);
      chk({7'b0, rx_irq[1]}, 8'h01, "R7 rx_irq set");
      chk({7'b0, rx_ready[1]}, 8'h00, "R7 ready drops with char");
      rx_offer(1, 8'h11);
      rd(A_DAT, 8'hA5, "R8 data read returns byte");
      chk({7'b0, rx_irq[1]}, 8'h00, "R8 rx_irq cleared");
      rd(A_CTL, 8'h44, "R8 char bit cleared");
      rx_offer(1, 8'h22);
      rd(A_DAT, 8'h22, "R7 held-off byte dropped");
      // R6 transmit
      wr(B_CTL, 8'h05); wr(B_CTL, 8'h08);
      wr_dat(0, 8'h5A, 1'b1);
      chk({7'b0, tx_irq[0]}, 8'h01, "R6 tx_irq B set");
      wr_dat(1, 8'h33, 1'b0);
      wr(A_CTL, 8'h01);
      rd(A_CTL, 8'h07, "R6 all-sent bit");
      chk({7'b0, tx_irq[1]}, 8'h01, "R6 tx_irq A set");
      wr(A_CTL, 8'h28);
      chk({7'b0, tx_irq[1]}, 8'h00, "R10 tx ack clears A");
      chk({7'b0, tx_irq[0]}, 8'h01, "R1 R10 B unaffected");
      // R11
      wr(A_CTL, 8'h38);
      chk({6'b0, ius_done}, 8'h02, "R11 ius pulse");
      @(negedge clk);
      chk({6'b0, ius_done}, 8'h00, "R11 pulse one cycle");
      // R9
      rx_break[0] = 1'b1; @(negedge clk); rx_break[0] = 1'b0;
      rd(B_CTL, 8'hC4, "R9 break bit B");
      rd(A_CTL, 8'h44, "R1 R9 A untouched");
      // R4: code 00 is stored, no reset
      wr(A_CTL, 8'h09); wr(A_CTL, 8'h10);
      chk({7'b0, rx_ready[1]}, 8'h01, "R4 code 00 no reset");
      // R4: reset B from A
      rx_offer(1, 8'h77);
      wr(A_CTL, 8'h09); wr(A_CTL, 8'h40);
      rd(B_CTL, 8'h44, "R4 B back to reset");
      wr_dat(0, 8'h12, 1'b0);
      rd(A_CTL, 8'h45, "R4 A kept its char");
      // R4: reset A from B
      wr(B_CTL, 8'h09); wr(B_CTL, 8'h80);
      rd(A_CTL, 8'h44, "R4 A back to reset");
      rd(A_DAT, 8'h00, "R4 A rx byte cleared");
      chk({7'b0, rx_ready[1]}, 8'h00, "R4 A rx disabled");
      // R4: reset both
      wr(B_CTL, 8'h03); wr(B_CTL, 8'h01);
      chk({7'b0, rx_ready[0]}, 8'h01, "R4 B rx enabled");
      wr(B_CTL, 8'h09); wr(B_CTL, 8'hC0);
      chk({6'b0, rx_ready}, 8'h00, "R4 both reset");
      chk({6'b0, tx_irq}, 8'h00, "R4 both tx_irq cleared");
      repeat (3) @(negedge clk);
      chk(8'(rd_exp_q.size() + tx_exp_q0.size() + tx_exp_q1.size()), 8'h00,
          "R6 R12 scoreboard drained");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule